// File: doc/BRIEF.md
# Wired Interrupt Aggregator

This block gathers 32 interrupt inputs into one wired interrupt line for a parent controller. Each input passes through a two-flop synchroniser and then a detector. One control bit picks the detection style for every input at once: level-high or rising-edge. A detected input latches a pending bit in the cause register. A per-input mask bit decides whether that pending bit can drive the output.

Software reaches the block through a simple 32-bit register bus. A write strobe with a byte offset writes a register. The read data is decoded from the offset with no wait cycles. Software acknowledges an input by writing a 0 to its cause bit. Writing a 1 to the set-cause register fires an input again, with no change on the input pin. A second control bit holds the message-signalled path off. No such path exists here, so that bit is only stored.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, cause reads 0x00000000, mask reads 0xFFFFFFFF, control reads 0x00000000 and `irq_o` is 0.
- R2: Byte offsets: cause 0x00, set-cause 0x08, mask 0x10, control 0x28. Mask reads back as written. Control keeps only bit 3 and bit 5, and its other bits read 0. Set-cause and unmapped offsets read 0.
- R3: With control bit 3 at 0 (level mode), a cause bit is set in every cycle its synchronised input is high. A bit cleared while its input stays high is set again. An input change at the pins reaches the cause register on the third rising clock edge.
- R4: With control bit 3 at 1 (edge mode), a cause bit is set only when its synchronised input goes from 0 to 1. It stays set while the input stays high, until software clears it.
- R5: A write to cause clears every bit where the written data is 0 and leaves every bit where it is 1. Writing 0x00000000 clears all pending bits.
- R6: A write of 1 to a set-cause bit sets that cause bit. Zero bits in that write leave cause unchanged.
- R7: When a detected input and a cause-register clear hit the same bit in the same cycle, the bit ends up set.
- R8: A mask bit of 1 keeps that cause bit from asserting `irq_o`. Writing all ones masks every input.
- R9: `irq_o` is a register. It is 1 in the cycle after any bit of (cause AND NOT mask) is 1, and 0 otherwise.
- R10: Control bit 5 has no effect on `irq_o` or cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Asynchronous interrupt inputs |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Wired interrupt towards the parent |

## Verification
The hardest case is the same-cycle conflict: a clear to the cause register arrives in the same cycle that a level input, or a fresh edge, sets the same bit. The bench sets this up on purpose. It holds an input high in level mode and writes zero to cause. It also times random input toggles three edges ahead of random cause writes. A cycle-stepped reference model follows the synchroniser delay, so each outcome is checked exactly.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int NUM_SRC   = 32;
    localparam int ADDR_W    = 6;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_SET   = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h28;
    localparam int CTRL_EDGE_BIT = 3;
    localparam int CTRL_MSI_BIT  = 5;

    typedef struct packed {
        logic [NUM_SRC-1:0] cause;
        logic [NUM_SRC-1:0] mask;
        logic               edge_mode;
        logic               msi_off;
        logic               irq;
    } agg_state_t;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqagg_detect.sv
module irqagg_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_i,
    input  logic             edge_mode_i,
    output logic [WIDTH-1:0] hit_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb prev_d = sync_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        assign hit_o[g] = edge_mode_i ? (sync_i[g] & ~prev_q[g]) : sync_i[g];
    end

    // edge mode: a held-high input reports only once
    AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && (hit_o != '0)) |=> !edge_mode_i || ((hit_o & $past(hit_o)) == '0)); // R4
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic               irq_o
);
    localparam logic [NUM_SRC-1:0] ALL_ONES = '1;

    agg_state_t         st_d, st_q;
    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] src_hit;
    logic               wr_cause, wr_set, wr_mask, wr_ctrl;

    irqagg_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    irqagg_detect #(.WIDTH(NUM_SRC)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (src_sync),
        .edge_mode_i (st_q.edge_mode),
        .hit_o       (src_hit)
    );

    assign wr_cause = wr_en_i && (addr_i == OFS_CAUSE);
    assign wr_set   = wr_en_i && (addr_i == OFS_SET);
    assign wr_mask  = wr_en_i && (addr_i == OFS_MASK);
    assign wr_ctrl  = wr_en_i && (addr_i == OFS_CTRL);

    always_comb begin
        logic [NUM_SRC-1:0] keep;
        logic [NUM_SRC-1:0] setv;
        st_d = st_q;
        keep = wr_cause ? wdata_i[NUM_SRC-1:0] : ALL_ONES;
        setv = src_hit | (wr_set ? wdata_i[NUM_SRC-1:0] : '0);
        st_d.cause = (st_q.cause & keep) | setv;
        if (wr_mask) st_d.mask = wdata_i[NUM_SRC-1:0];
        if (wr_ctrl) begin
            st_d.edge_mode = wdata_i[CTRL_EDGE_BIT];
            st_d.msi_off   = wdata_i[CTRL_MSI_BIT];
        end
        st_d.irq = |(st_q.cause & ~st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cause     <= '0;
            st_q.mask      <= ALL_ONES;
            st_q.edge_mode <= 1'b0;
            st_q.msi_off   <= 1'b0;
            st_q.irq       <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_CAUSE: rdata_o[NUM_SRC-1:0] = st_q.cause;
            OFS_MASK:  rdata_o[NUM_SRC-1:0] = st_q.mask;
            OFS_CTRL: begin
                rdata_o[CTRL_EDGE_BIT] = st_q.edge_mode;
                rdata_o[CTRL_MSI_BIT]  = st_q.msi_off;
            end
            default:   rdata_o = '0;
        endcase
    end

    assign irq_o = st_q.irq;

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((st_q.cause & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0]))); // R6
    AST_ONES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cause |=> ((st_q.cause & $past(st_q.cause & wdata_i[NUM_SRC-1:0]))
                      == $past(st_q.cause & wdata_i[NUM_SRC-1:0]))); // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cause |=> ((st_q.cause & $past(st_q.cause)) == $past(st_q.cause))); // R4
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cause & ~st_q.mask) == '0) |=> !irq_o); // R8
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(st_q.cause != '0)); // R9
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        wr_en_i = 1'b0;
    logic [5:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int total = 0;
    int bad   = 0;

    // reference model state
    logic [31:0] m_s1, m_s2, m_prv, m_cause, m_mask;
    logic        m_edge, m_msi, m_irq;

    always #10 clk = ~clk;

    irq_aggregator u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    function automatic logic [31:0] next_cause(logic [31:0] c, logic [31:0] s2, logic [31:0] prv,
                                               logic edm, logic wr, logic [5:0] a, logic [31:0] d);
        logic [31:0] hit;
        logic [31:0] r;
        hit = edm ? (s2 & ~prv) : s2;
        r = c;
        if (wr && a == 6'h00) r = r & d;
        if (wr && a == 6'h08) r = r | d;
        return r | hit;
    endfunction

    function automatic logic [31:0] read_model(logic [5:0] a);
        case (a)
            6'h00:   return m_cause;
            6'h10:   return m_mask;
            6'h28:   return {26'd0, m_msi, 1'b0, m_edge, 3'd0};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prv = '0; m_cause = '0; m_mask = '1;
            m_edge = 1'b0; m_msi = 1'b0; m_irq = 1'b0;
        end else begin
            m_irq   = |(m_cause & ~m_mask);
            m_cause = next_cause(m_cause, m_s2, m_prv, m_edge, wr_en_i, addr_i, wdata_i);
            if (wr_en_i && addr_i == 6'h10) m_mask = wdata_i;
            if (wr_en_i && addr_i == 6'h28) begin
                m_edge = wdata_i[3];
                m_msi  = wdata_i[5];
            end
            m_prv = m_s2;
            m_s2  = m_s1;
            m_s1  = src_i;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock, then compare irq_o on the falling edge
    task automatic tick(string tag);
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b0;
        check(tag, {31'd0, irq_o}, {31'd0, m_irq});
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d, string tag);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        tick(tag);
    endtask

    task automatic rd(logic [5:0] a, string tag);
        wr_en_i = 1'b0; addr_i = a;
        #1;
        check(tag, rdata_o, read_model(a));
    endtask

    initial begin
        #3_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        addr_i = 6'h00; #1; check("R1 cause", rdata_o, 32'h0);
        addr_i = 6'h10; #1; check("R1 mask", rdata_o, 32'hFFFF_FFFF);
        addr_i = 6'h28; #1; check("R1 ctrl", rdata_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 map and readback
        wr(6'h10, 32'hA5A5_0F0F, "R2 wr");
        rd(6'h10, "R2 mask");
        wr(6'h28, 32'hFFFF_FFFF, "R2 wr");
        rd(6'h28, "R2 ctrl");
        addr_i = 6'h28; #1; check("R2 ctrl const", rdata_o, 32'h28);
        wr(6'h28, 32'h0, "R2 wr");
        rd(6'h08, "R2 setcause");
        rd(6'h3C, "R2 unmapped");

        // R3 level mode latency and re-assert
        wr(6'h10, 32'h0, "R8 unmask");
        src_i = 32'h1;
        tick("R3"); tick("R3");
        addr_i = 6'h00; #1; check("R3 before third edge", rdata_o, 32'h0);
        tick("R3");
        addr_i = 6'h00; #1; check("R3 third edge", rdata_o, 32'h1);
        tick("R9"); check("R9 irq", {31'd0, irq_o}, 32'd1);
        wr(6'h00, 32'h0, "R7 clear vs level");
        addr_i = 6'h00; #1; check("R7 level wins", rdata_o, 32'h1);
        src_i = 32'h0;
        repeat (3) tick("R3");
        wr(6'h00, 32'h0, "R5 clear all");
        rd(6'h00, "R5 cleared");
        addr_i = 6'h00; #1; check("R5 cleared const", rdata_o, 32'h0);

        // R4 edge mode: held input reports once
        wr(6'h28, 32'h8, "R4 wr");
        src_i = 32'h0000_0012;
        repeat (4) tick("R4");
        addr_i = 6'h00; #1; check("R4 edge set", rdata_o, 32'h12);
        wr(6'h00, 32'hFFFF_FFEF, "R5 clear one");
        addr_i = 6'h00; #1; check("R5 one bit cleared", rdata_o, 32'h02);
        repeat (3) tick("R4");
        addr_i = 6'h00; #1; check("R4 no re-set while high", rdata_o, 32'h02);

        // R6 set-cause
        wr(6'h08, 32'h8000_0000, "R6 wr");
        addr_i = 6'h00; #1; check("R6 set", rdata_o, 32'h8000_0002);
        wr(6'h08, 32'h0, "R6 zero");
        rd(6'h00, "R6 zero no effect");

        // R8 mask all, R10 msi bit
        wr(6'h10, 32'hFFFF_FFFF, "R8 mask all");
        repeat (2) tick("R8");
        check("R8 masked", {31'd0, irq_o}, 32'd0);
        wr(6'h10, 32'h7FFF_FFFF, "R8 unmask one");
        wr(6'h28, 32'h28, "R10 msi on");
        tick("R10");
        check("R10 irq", {31'd0, irq_o}, 32'd1);
        rd(6'h00, "R10 cause");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int op;
            if ($urandom_range(0, 3) == 0) src_i = $urandom;
            op = $urandom_range(0, 9);
            case (op)
                0: begin addr_i = 6'h00; wdata_i = $urandom; wr_en_i = 1'b1; end
                1: begin addr_i = 6'h00; wdata_i = 32'h0; wr_en_i = 1'b1; end
                2: begin addr_i = 6'h08; wdata_i = 32'h1 << $urandom_range(0, 31); wr_en_i = 1'b1; end
                3: begin addr_i = 6'h10; wdata_i = $urandom | $urandom; wr_en_i = 1'b1; end
                4: begin addr_i = 6'h28; wdata_i = $urandom; wr_en_i = 1'b1; end
                default: wr_en_i = 1'b0;
            endcase
            tick("R9 random");
            if (i % 8 == 0) rd(6'h00, "R7 random cause");
            if (i % 64 == 0) rd(6'h28, "R2 random ctrl");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule